// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the twelve interrupt-capable pins of one general-purpose I/O port and turns pin activity into an interrupt request. Each pin is set up on its own as edge-triggered (rising, falling or both edges) or level-triggered (active high or active low). A pin that meets its condition sets a bit in a raw status view, which ignores the mask. A masked view ANDs that status with a per-pin enable. Software acknowledges edge events by writing ones to a write-only clear location. Level-triggered bits cannot be cleared that way, because they follow the pin.

Pin inputs pass through a two-flop synchronizer before detection. The OR of all masked bits goes through a two-register delay on its way to the interrupt controller, so the request lags the masked status by two clocks. Configuration and status sit on a simple 32-bit write/read register bus. Reads are combinational from the presented address. Bits above the pin count always read zero.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every readable location (trigger mode, polarity, both-edge, enable, raw status, masked status) reads 0 and `irq_out` is 0.
- R2: Bits 31:12 of every read are 0. The clear location (0x1C) reads 0. Writes to the raw (0x14) and masked (0x18) locations change nothing.
- R3: Masked status at offset 0x18 reads raw status AND the enable register at offset 0x10 (1 = enabled).
- R4: With mode bit 0 (edge; mode register at 0x04), a qualifying edge latches the raw bit at 0x14 and it stays set until cleared. Polarity register 0x0C bit 1 selects rising and 0 selects falling. Both-edge register 0x08 bit 1 takes either edge and overrides polarity.
- R5: With mode bit 1 (level), the raw bit is 1 while the synchronized pin equals the polarity bit (1 = high active). A clear write does not change it.
- R6: Writing 1 to a bit of the clear location 0x1C resets the latched edge bit of that pin in the following cycle. Writing 0 leaves it unchanged.
- R7: A clear written in the same cycle as a new qualifying edge on that pin leaves the raw bit set.
- R8: An edge on a pin shows in raw status after the third rising clock edge that samples the new pin value, and not after the second.
- R9: `irq_out` equals the OR of all masked status bits as they stood two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 12 | Asynchronous pin levels |
| bus_we | input | 1 | Write strobe, sampled on the clock |
| bus_addr | input | 8 | Byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Port interrupt request toward the controller |

## Verification
The bench drives a clear into the exact cycle in which a rising edge is being detected. A design that let the clear win would drop that event, and the raw bit would read 0. It writes ones to the clear location while level-triggered pins are active. A design that cleared those bits would briefly show a hole in the raw status. The latency is probed one edge early and one edge on time, for both the raw bit and the request. This catches a synchronizer or delay stage that was added or lost. Long random runs mix mode, polarity and both-edge rewrites with random clears. They are compared every clock against a behavioural model, which exposes stale latched bits left behind when a pin moves from edge mode to level mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned OFS_W = 8;
   // register byte offsets
   localparam logic [OFS_W-1:0] OFS_MODE   = 8'h04;  // 1 = level
   localparam logic [OFS_W-1:0] OFS_BOTH   = 8'h08;  // 1 = either edge
   localparam logic [OFS_W-1:0] OFS_POL    = 8'h0C;  // 1 = rising / high
   localparam logic [OFS_W-1:0] OFS_ENA    = 8'h10;  // 1 = enabled
   localparam logic [OFS_W-1:0] OFS_RAW    = 8'h14;
   localparam logic [OFS_W-1:0] OFS_MASKED = 8'h18;
   localparam logic [OFS_W-1:0] OFS_CLEAR  = 8'h1C;
endpackage

// File: rtl/gpio_irq_sync.sv
// Reset-to-zero register chain, used for pin sync and request delay.
module gpio_irq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("gpio_irq_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_wire
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin edge/level detection and latched edge status.
module gpio_irq_detect #(
   parameter int unsigned N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_s,
   input  logic [N-1:0] mode_lvl,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] both,
   input  logic [N-1:0] clr,
   output logic [N-1:0] edge_evt,
   output logic [N-1:0] raw_st
);
   logic [N-1:0] prev_q;
   logic [N-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   for (genvar i = 0; i < int'(N); i++) begin : g_pin
      logic rise, fall;
      assign rise = pin_s[i] & ~prev_q[i];
      assign fall = ~pin_s[i] & prev_q[i];
      assign edge_evt[i] = both[i] ? (rise | fall) : (pol[i] ? rise : fall);

      // new edge beats a simultaneous clear; level mode holds no latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lat_q[i] <= 1'b0;
         else        lat_q[i] <= ~mode_lvl[i] & (edge_evt[i] | (lat_q[i] & ~clr[i]));
      end

      assign raw_st[i] = mode_lvl[i] ? (pin_s[i] == pol[i]) : lat_q[i];
   end
endmodule

// File: rtl/gpio_irq_regs.sv
// Configuration registers, clear strobe and read multiplexer.
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N  = 12,
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [N-1:0]  raw_st,
   input  logic [N-1:0]  masked_st,
   output logic [N-1:0]  mode_q,
   output logic [N-1:0]  pol_q,
   output logic [N-1:0]  both_q,
   output logic [N-1:0]  ena_q,
   output logic [N-1:0]  clr_hit,
   output logic [DW-1:0] bus_rdata
);
   if (N > DW) begin : g_bad_n
      $error("gpio_irq_regs: pin count exceeds data width");
   end
   if (AW < OFS_W) begin : g_bad_aw
      $error("gpio_irq_regs: address too narrow for the register map");
   end

   logic [N-1:0] wfield;
   assign wfield = bus_wdata[N-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
         ena_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == AW'(OFS_MODE)) mode_q <= wfield;
         if (bus_addr == AW'(OFS_POL))  pol_q  <= wfield;
         if (bus_addr == AW'(OFS_BOTH)) both_q <= wfield;
         if (bus_addr == AW'(OFS_ENA))  ena_q  <= wfield;
      end
   end

   assign clr_hit = (bus_we && bus_addr == AW'(OFS_CLEAR)) ? wfield : '0;

   logic [N-1:0] rd_n;
   always_comb begin
      rd_n = '0;
      if      (bus_addr == AW'(OFS_MODE))   rd_n = mode_q;
      else if (bus_addr == AW'(OFS_POL))    rd_n = pol_q;
      else if (bus_addr == AW'(OFS_BOTH))   rd_n = both_q;
      else if (bus_addr == AW'(OFS_ENA))    rd_n = ena_q;
      else if (bus_addr == AW'(OFS_RAW))    rd_n = raw_st;
      else if (bus_addr == AW'(OFS_MASKED)) rd_n = masked_st;
   end
   assign bus_rdata = DW'(rd_n);
endmodule

// File: rtl/gpio_irq_port.sv
// Port interrupt detector top: pin sync, detection, registers, request delay.
module gpio_irq_port #(
   parameter int unsigned NUM_PINS    = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned IN_SYNC     = 2,
   parameter int unsigned IRQ_DELAY   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_out
);
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_port: need at least one pin");
   end

   logic [NUM_PINS-1:0] pin_s, mode_q, pol_q, both_q, ena_q, clr_hit;
   logic [NUM_PINS-1:0] edge_evt, raw_st, masked_st;
   logic                irq_pre;

   gpio_irq_sync #(.W(NUM_PINS), .STAGES(IN_SYNC)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   gpio_irq_regs #(.N(NUM_PINS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .raw_st(raw_st), .masked_st(masked_st),
      .mode_q(mode_q), .pol_q(pol_q), .both_q(both_q), .ena_q(ena_q),
      .clr_hit(clr_hit), .bus_rdata(bus_rdata)
   );

   gpio_irq_detect #(.N(NUM_PINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s),
      .mode_lvl(mode_q), .pol(pol_q), .both(both_q), .clr(clr_hit),
      .edge_evt(edge_evt), .raw_st(raw_st)
   );

   assign masked_st = raw_st & ena_q;
   assign irq_pre   = |masked_st;

   gpio_irq_sync #(.W(1), .STAGES(IRQ_DELAY)) u_irq_dly (
      .clk(clk), .rst_n(rst_n), .d(irq_pre), .q(irq_out)
   );
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Property checker attached to gpio_irq_port.
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N         = 12,
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 8,
   parameter int unsigned IRQ_DELAY = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  mode_q,
   input logic [N-1:0]  ena_q,
   input logic [N-1:0]  clr_hit,
   input logic [N-1:0]  edge_evt,
   input logic [N-1:0]  raw_st,
   input logic          irq_pre,
   input logic          irq_out,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_rdata
);
   // R3: masked read equals raw AND enable
   a_r3_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(OFS_MASKED)) |-> (bus_rdata[N-1:0] == (raw_st & ena_q)));

   if (DW > N) begin : g_resv
      // R2: unused upper bits read zero
      a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[DW-1:N] == '0);
   end

   // R4: a latched edge bit holds while no clear arrives
   a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(raw_st & ~mode_q & ~clr_hit) & ~mode_q & ~raw_st) == '0));

   // R6: a clear with no new edge empties the bit
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_hit & ~mode_q & ~edge_evt) & ~mode_q & raw_st) == '0));

   // R7: an edge coinciding with a clear keeps the bit set
   a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(edge_evt & ~mode_q & clr_hit)) |=>
      (($past(edge_evt & ~mode_q & clr_hit) & ~mode_q & ~raw_st) == '0));

   if (IRQ_DELAY == 2) begin : g_dly
      // R9: request lags the combined masked status by two clocks
      a_r9_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out == $past(irq_pre, 2));
   end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .N(NUM_PINS), .DW(DATA_W), .AW(ADDR_W), .IRQ_DELAY(IRQ_DELAY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ena_q(ena_q),
   .clr_hit(clr_hit), .edge_evt(edge_evt), .raw_st(raw_st),
   .irq_pre(irq_pre), .irq_out(irq_out),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
   localparam int N = 12;
   localparam logic [7:0] A_MODE = 8'h04, A_BOTH = 8'h08, A_POL = 8'h0C,
                          A_ENA = 8'h10, A_RAW = 8'h14, A_MSK = 8'h18,
                          A_CLR = 8'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = A_RAW;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gpio_irq_port u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // behavioural reference
   logic [N-1:0] ms1, ms2, mp, mlat, mmode, mpol, mboth, mena;
   bit irq_q[$] = '{1'b0, 1'b0};

   function automatic logic [N-1:0] m_raw();
      return (mmode & ~(ms2 ^ mpol)) | (~mmode & mlat);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ms1 = '0; ms2 = '0; mp = '0; mlat = '0;
         mmode = '0; mpol = '0; mboth = '0; mena = '0;
         irq_q = '{1'b0, 1'b0};
      end else begin
         logic [N-1:0] clr, evt, nlat;
         bit pre;
         clr = (bus_we && bus_addr == A_CLR) ? bus_wdata[N-1:0] : '0;
         for (int i = 0; i < N; i++) begin
            bit r, f;
            r = ms2[i] && !mp[i];
            f = !ms2[i] && mp[i];
            evt[i] = mboth[i] ? (r || f) : (mpol[i] ? r : f);
         end
         pre  = |(m_raw() & mena);
         nlat = ~mmode & (evt | (mlat & ~clr));
         if (bus_we) begin
            case (bus_addr)
               A_MODE: mmode = bus_wdata[N-1:0];
               A_POL:  mpol  = bus_wdata[N-1:0];
               A_BOTH: mboth = bus_wdata[N-1:0];
               A_ENA:  mena  = bus_wdata[N-1:0];
               default: ;
            endcase
         end
         mlat = nlat;
         mp = ms2; ms2 = ms1; ms1 = pin_in;
         irq_q.push_back(pre);
         void'(irq_q.pop_front());
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // one clock; compare request and idle raw read against the model
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      chk("R9", "irq_out per-cycle", {31'b0, irq_out}, {31'b0, irq_q[0]});
      if (bus_addr == A_RAW)
         chk("R4 R5", "raw per-cycle", bus_rdata, 32'(m_raw()));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0; bus_addr = A_RAW; bus_wdata = '0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, $sformatf("read 0x%h", a), bus_rdata, exp);
      bus_addr = A_RAW;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd("R1", A_MODE, 0); rd("R1", A_POL, 0); rd("R1", A_BOTH, 0);
      rd("R1", A_ENA, 0);  rd("R1", A_RAW, 0); rd("R1", A_MSK, 0);
      chk("R1", "irq after reset", {31'b0, irq_out}, 0);

      // configure: 0-3 rising, 4-5 falling, 6-7 both, 8-9 level high, 10-11 level low
      wr(A_MODE, 32'hFFFF_FF00);
      rd("R2", A_MODE, 32'h0000_0F00);
      wr(A_POL, 32'h30F); wr(A_BOTH, 32'h0C0); wr(A_ENA, 32'hFFF);
      repeat (3) tick();
      rd("R5", A_RAW, 32'hC00);
      wr(A_RAW, 32'hFFF); wr(A_MSK, 32'hFFF);
      rd("R2", A_RAW, 32'hC00);
      rd("R2", A_ENA, 32'hFFF);
      rd("R2", A_CLR, 0);

      // R4 edges
      pin_in = 12'h0FF; repeat (3) tick();
      rd("R4", A_RAW, 32'hCCF);
      pin_in = 12'h000; repeat (3) tick();
      rd("R4", A_RAW, 32'hCFF);

      // R5 level pins
      pin_in = 12'hF00; repeat (2) tick();
      rd("R5", A_RAW, 32'h3FF);
      wr(A_CLR, 32'hF00);
      rd("R5", A_RAW, 32'h3FF);

      // R6 clear
      wr(A_CLR, 32'h00F);
      rd("R6", A_RAW, 32'h3F0);
      wr(A_CLR, 32'h000);
      rd("R6", A_RAW, 32'h3F0);

      // R3 masking
      wr(A_ENA, 32'h5A5);
      rd("R3", A_MSK, 32'h1A0);

      // R7 edge beats clear in the same cycle
      wr(A_CLR, 32'h0F0);
      rd("R6", A_RAW, 32'h300);
      pin_in = 12'hF01; tick(); tick();
      wr(A_CLR, 32'h001);
      rd("R7", A_RAW, 32'h301);
      wr(A_CLR, 32'h001);
      rd("R6", A_RAW, 32'h300);

      // R8 / R9 latency
      wr(A_ENA, 32'h001);
      pin_in = 12'hF00; repeat (3) tick();
      rd("R4", A_RAW, 32'h300);
      chk("R9", "irq idle", {31'b0, irq_out}, 0);
      pin_in = 12'hF01; tick(); tick();
      rd("R8", A_RAW, 32'h300);
      tick();
      rd("R8", A_RAW, 32'h301);
      chk("R9", "irq at raw set", {31'b0, irq_out}, 0);
      tick();
      chk("R9", "irq one later", {31'b0, irq_out}, 0);
      tick();
      chk("R9", "irq two later", {31'b0, irq_out}, 1);

      // random mix against the model
      for (int c = 0; c < 4000; c++) begin
         int sel;
         if ($urandom_range(0, 2) == 0) pin_in = N'($urandom);
         sel = $urandom_range(0, 31);
         if (sel < 4)       wr(A_CLR, $urandom);
         else if (sel == 4) wr(A_MODE, $urandom);
         else if (sel == 5) wr(A_POL, $urandom);
         else if (sel == 6) wr(A_BOTH, $urandom);
         else if (sel == 7) wr(A_ENA, $urandom);
         else tick();
         if (c % 97 == 0) rd("R3", A_MSK, 32'(m_raw() & mena));
      end

      summary();
      $finish;
   end
endmodule